// File: doc/BRIEF.md
# Instruction Decode Steering Allocator

This block is the steering stage at the front of a legacy instruction decoder that has one complex decoder and several simple decoders. Each cycle it looks at a window of up to four pre-decoded instructions, already split into fields: an operand-size prefix flag, a 64-bit operand flag, the opcode map, the opcode byte, the reg and mod fields of the ModRM byte, and the vector length bit. Each lane runs a deliberately coarse pattern match that tags the instruction as "may need several uops" or "simple". The match works on whole opcodes or opcode groups and accepts false positives on purpose. As a result, single-uop forms that share an opcode with a multi-uop form are pushed onto the complex decoder.

The allocator then hands out a contiguous group of instructions in program order. The complex decoder (slot 0) always takes the oldest instruction. The simple decoders take the following instructions, and only while each of them is tagged simple. The block registers a per-slot valid mask, a per-slot complex flag and the number of instructions it consumed, and the upstream queue advances by that number. A stream made only of complex-tagged instructions therefore moves at one instruction per clock.

Opcode maps are coded 0 for one-byte opcodes, 1 for the 0F map, 2 for the 0F38 map and 3 for the 0F3A map.

Top module: `decode_steer`

## Requirements
- R1: While reset is low, and after it until a valid window arrives, every bit of slot_valid and slot_cplx is 0 and consumed is 0.
- R2: When lane 0 is valid and stall is low, slot 0 takes lane 0 whatever its class. slot_cplx[0] then equals the class of lane 0. slot_cplx bits 1 to 3 are always 0.
- R3: Slot k (k of 1 to 3) is valid only if lanes 0 to k are all valid and lanes 1 to k are all classed simple. The group ends just before the first complex-classed lane after lane 0, so slot_valid always has the form of ones from bit 0 upward.
- R4: A window whose valid mask has fewer ones is allocated only up to its first invalid lane. A window with lane 0 invalid gives slot_valid = 0 and consumed = 0.
- R5: In the cycle after stall is sampled high, slot_valid and slot_cplx keep their previous values and consumed is 0.
- R6: One-byte opcodes 98h and 99h (map 0) are classed complex for every value of the operand-size prefix flag and the 64-bit operand flag.
- R7: 0F C8h to 0F CFh (byte swap) are classed complex whether the 64-bit operand flag is set or clear.
- R8: Every conditional set opcode (0F 90h to 0F 9Fh) and every conditional move opcode (0F 40h to 0F 4Fh) is classed complex.
- R9: The bit-test opcodes 0F A3h, 0F ABh, 0F B3h and 0F BBh are classed complex for every mod value, and so is 0F BAh with ModRM reg 4 to 7. 0F BAh with reg 0 to 3 is simple.
- R10: Map 2 opcodes 20h to 25h and 30h to 35h (sign and zero extension) are classed complex when the vector length bit is 1, and simple when it is 0.
- R11: Map 3 opcodes 18h and 21h (insert forms) are classed complex when mod is not 3, and simple when mod is 3.
- R12: 0F 18h with ModRM reg 0 to 3 (prefetch hints) and 0F B8h (population count) are classed complex. 0F 18h with reg 4 to 7 is simple.
- R13: One-byte opcode 14h (accumulator add-with-carry, 8-bit immediate) is classed complex. Every opcode not named in R6 to R12, including 80h, 81h and 83h with any reg field, is classed simple.
- R14: Outputs are registered. A window presented before a rising edge shows on the outputs after that edge, and when the previous cycle was not stalled, consumed equals the number of ones in slot_valid.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| stall | input | 1 | Hold the outputs and consume nothing |
| win_valid | input | 4 | Per-lane valid; lane 0 is the oldest |
| win_pfx66 | input | 4 | Per-lane operand-size prefix flag |
| win_rexw | input | 4 | Per-lane 64-bit operand flag |
| win_map | input | 8 | Per-lane opcode map, 2 bits per lane |
| win_opc | input | 32 | Per-lane opcode byte, 8 bits per lane |
| win_reg | input | 12 | Per-lane ModRM reg field, 3 bits per lane |
| win_mod | input | 8 | Per-lane ModRM mod field, 2 bits per lane |
| win_vexl | input | 4 | Per-lane vector length bit |
| slot_valid | output | 4 | Per-slot valid; slot 0 is the complex decoder |
| slot_cplx | output | 4 | Per-slot complex flag |
| consumed | output | 3 | Instructions taken from the window, 0 to 4 |

## Verification
Every result of the block goes through exactly one register. A window driven on a falling edge is therefore due on slot_valid, slot_cplx and consumed after the next rising edge, and the bench drives on one falling edge and samples on the next. The outputs are also read just after a new window is driven, before the edge, to confirm that they have not yet moved. After a stalled edge the held values are due in that same next-falling-edge sample. The classifier sweep walks every opcode in every map against the reg, mod, vector-length and prefix fields, one window per cycle, so each class result is compared one cycle after its stimulus.

// File: rtl/steer_pkg.sv
// Package steer_pkg
// Shared encodings for the decode steering block: the opcode map codes and
// the per-lane instruction fields that the classifier looks at.
// Assumes the pre-decoder has already resolved the map and split out the ModRM fields.
package steer_pkg;

    localparam logic [1:0] MAP_ONE  = 2'd0;  // one-byte opcodes
    localparam logic [1:0] MAP_0F   = 2'd1;  // 0F escape
    localparam logic [1:0] MAP_0F38 = 2'd2;  // 0F 38 escape
    localparam logic [1:0] MAP_0F3A = 2'd3;  // 0F 3A escape

    // Fields the class match depends on
    typedef struct packed {
        logic [1:0] omap;
        logic [7:0] opc;
        logic [2:0] mreg;
        logic [1:0] mmod;
        logic       vexl;
    } insn_t;

endpackage

// File: rtl/steer_classify.sv
// Module steer_classify
// Coarse, conservative class match for one lane. It raises may_multi for any
// opcode or opcode group that has at least one multi-uop form, except where
// the mod or vector length field is checked on purpose.
// Assumes a purely combinational use; no clock.
module steer_classify
    import steer_pkg::*;
(
    input  insn_t ins,
    output logic  may_multi
);

    // Per-map opcode pattern match
    always_comb begin
        may_multi = 1'b0;
        unique case (ins.omap)
            MAP_ONE: begin
                may_multi = (ins.opc == 8'h98) || (ins.opc == 8'h99) ||
                            (ins.opc == 8'h14);
            end
            MAP_0F: begin
                may_multi = (ins.opc[7:3] == 5'b11001)               // byte swap
                         || (ins.opc[7:4] == 4'h9)                   // set on condition
                         || (ins.opc[7:4] == 4'h4)                   // move on condition
                         || (ins.opc == 8'hA3) || (ins.opc == 8'hAB)
                         || (ins.opc == 8'hB3) || (ins.opc == 8'hBB)
                         || ((ins.opc == 8'hBA) && ins.mreg[2])      // bit test, immediate
                         || ((ins.opc == 8'h18) && !ins.mreg[2])     // prefetch hints
                         || (ins.opc == 8'hB8);                      // population count
            end
            MAP_0F38: begin
                may_multi = ins.vexl &&
                            (((ins.opc >= 8'h20) && (ins.opc <= 8'h25)) ||
                             ((ins.opc >= 8'h30) && (ins.opc <= 8'h35)));
            end
            MAP_0F3A: begin
                may_multi = (ins.mmod != 2'd3) &&
                            ((ins.opc == 8'h18) || (ins.opc == 8'h21));
            end
            default: may_multi = 1'b0;
        endcase
    end

endmodule

// File: rtl/steer_alloc.sv
// Module steer_alloc
// In-order slot allocation. Slot 0 takes lane 0 whenever it is valid. Each
// later slot takes its lane only while the chain of valid, simple lanes is unbroken.
// Assumes lane 0 is the oldest instruction; purely combinational.
module steer_alloc #(
    parameter  int LANES = 4,
    localparam int CW    = $clog2(LANES + 1)
) (
    input  logic [LANES-1:0] lane_valid,
    input  logic [LANES-1:0] lane_multi,
    output logic [LANES-1:0] take,
    output logic [LANES-1:0] cplx,
    output logic [CW-1:0]    count
);

    assign take[0] = lane_valid[0];
    assign cplx[0] = lane_valid[0] & lane_multi[0];

    genvar k;
    generate
        for (k = 1; k < LANES; k++) begin : g_chain
            assign take[k] = take[k-1] & lane_valid[k] & ~lane_multi[k];
            assign cplx[k] = 1'b0;
        end
    endgenerate

    // Count of lanes taken this cycle
    always_comb begin
        count = '0;
        for (int i = 0; i < LANES; i++) begin
            count = count + CW'(take[i]);
        end
    end

endmodule

// File: rtl/decode_steer.sv
// Module decode_steer
// Top of the decode steering block: one class matcher per lane, the in-order
// allocator, and a registered output stage that freezes under stall.
// Assumes the window fields are stable around the rising edge and valid lanes
// are packed from lane 0.
module decode_steer
    import steer_pkg::*;
#(
    parameter  int LANES = 4,
    localparam int CW    = $clog2(LANES + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               stall,
    input  logic [LANES-1:0]   win_valid,
    input  logic [LANES-1:0]   win_pfx66,
    input  logic [LANES-1:0]   win_rexw,
    input  logic [2*LANES-1:0] win_map,
    input  logic [8*LANES-1:0] win_opc,
    input  logic [3*LANES-1:0] win_reg,
    input  logic [2*LANES-1:0] win_mod,
    input  logic [LANES-1:0]   win_vexl,
    output logic [LANES-1:0]   slot_valid,
    output logic [LANES-1:0]   slot_cplx,
    output logic [CW-1:0]      consumed
);

    logic [LANES-1:0] lane_multi;
    logic [LANES-1:0] take_n;
    logic [LANES-1:0] cplx_n;
    logic [CW-1:0]    count_n;

    genvar k;
    generate
        for (k = 0; k < LANES; k++) begin : g_lane
            insn_t ins;
            assign ins = '{omap: win_map[2*k +: 2],
                           opc:  win_opc[8*k +: 8],
                           mreg: win_reg[3*k +: 3],
                           mmod: win_mod[2*k +: 2],
                           vexl: win_vexl[k]};
            steer_classify u_cls (
                .ins       (ins),
                .may_multi (lane_multi[k])
            );

            // R6 (and R7): the prefix and 64-bit flags never make a 98h/99h or byte swap lane simple
            if (k == 0) begin : g_head
                assert_prefix_blind_R6: assert property (@(posedge clk) disable iff (!rst_n)
                    (win_valid[0] && !stall &&
                     (((win_map[1:0] == MAP_ONE) && (win_opc[7:1] == 7'h4C) &&
                       (win_pfx66[0] || win_rexw[0])) ||
                      ((win_map[1:0] == MAP_0F) && (win_opc[7:3] == 5'b11001) && !win_rexw[0])))
                    |=> slot_cplx[0]);
            end else begin : g_tail
                assert_prefix_blind_R6: assert property (@(posedge clk) disable iff (!rst_n)
                    (win_valid[k] && !stall &&
                     (((win_map[2*k +: 2] == MAP_ONE) && (win_opc[8*k+1 +: 7] == 7'h4C) &&
                       (win_pfx66[k] || win_rexw[k])) ||
                      ((win_map[2*k +: 2] == MAP_0F) && (win_opc[8*k+3 +: 5] == 5'b11001) &&
                       !win_rexw[k])))
                    |=> !slot_valid[k]);
            end
        end
    endgenerate

    steer_alloc #(.LANES(LANES)) u_alloc (
        .lane_valid (win_valid),
        .lane_multi (lane_multi),
        .take       (take_n),
        .cplx       (cplx_n),
        .count      (count_n)
    );

    // Output register: load the new group, or hold it and report nothing consumed under stall
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_valid <= '0;
            slot_cplx  <= '0;
            consumed   <= '0;
        end else if (stall) begin
            consumed   <= '0;
        end else begin
            slot_valid <= take_n;
            slot_cplx  <= cplx_n;
            consumed   <= count_n;
        end
    end

    // R3: the granted slots always form an unbroken run from slot 0
    assert_slot_run_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((slot_valid & (slot_valid + {{(LANES-1){1'b0}}, 1'b1})) == '0));

    // R2: only the complex decoder slot may carry the complex flag, and only when granted
    assert_cplx_head_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_cplx[LANES-1:1] == '0) && (!slot_cplx[0] || slot_valid[0]));

    // R2: a valid oldest lane is always granted slot 0 on an unstalled edge
    assert_head_taken_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (win_valid[0] && !stall) |=> slot_valid[0]);

    // R5: a stalled edge leaves the grant unchanged and consumes nothing
    assert_stall_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(stall) |-> ($stable(slot_valid) && $stable(slot_cplx) && (consumed == '0)));

    // R14: the consumed count agrees with the granted slots after an unstalled edge
    assert_count_match_R14: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(stall) |-> (consumed == CW'($countones(slot_valid))));

endmodule

// File: tb/decode_steer_test.sv
`timescale 1ns/1ps
module decode_steer_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        stall = 1'b0;
    logic [3:0]  win_valid = '0;
    logic [3:0]  win_pfx66 = '0;
    logic [3:0]  win_rexw = '0;
    logic [7:0]  win_map = '0;
    logic [31:0] win_opc = '0;
    logic [11:0] win_reg = '0;
    logic [7:0]  win_mod = '0;
    logic [3:0]  win_vexl = '0;
    logic [3:0]  slot_valid;
    logic [3:0]  slot_cplx;
    logic [2:0]  consumed;

    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    decode_steer uut (
        .clk(clk), .rst_n(rst_n), .stall(stall),
        .win_valid(win_valid), .win_pfx66(win_pfx66), .win_rexw(win_rexw),
        .win_map(win_map), .win_opc(win_opc), .win_reg(win_reg),
        .win_mod(win_mod), .win_vexl(win_vexl),
        .slot_valid(slot_valid), .slot_cplx(slot_cplx), .consumed(consumed)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s act=%0d exp=%0d", tag, what, act, exp);
        end
    endtask

    // Expected class from the requirement rules R6 to R13
    function automatic bit ref_multi(input int m, input int op, input int rg, input int md, input bit vl);
        case (m)
            0: return (op == 'h98) || (op == 'h99) || (op == 'h14);
            1: return ((op >= 'hC8) && (op <= 'hCF)) || ((op >= 'h90) && (op <= 'h9F)) ||
                      ((op >= 'h40) && (op <= 'h4F)) || (op == 'hA3) || (op == 'hAB) ||
                      (op == 'hB3) || (op == 'hBB) || ((op == 'hBA) && (rg >= 4)) ||
                      ((op == 'h18) && (rg < 4)) || (op == 'hB8);
            2: return vl && (((op >= 'h20) && (op <= 'h25)) || ((op >= 'h30) && (op <= 'h35)));
            default: return (md != 3) && ((op == 'h18) || (op == 'h21));
        endcase
    endfunction

    // Requirement that governs a given encoding
    function automatic string ref_tag(input int m, input int op);
        if (m == 0 && (op == 'h98 || op == 'h99)) return "R6";
        if (m == 1 && op >= 'hC8 && op <= 'hCF) return "R7";
        if (m == 1 && ((op >= 'h90 && op <= 'h9F) || (op >= 'h40 && op <= 'h4F))) return "R8";
        if (m == 1 && (op == 'hA3 || op == 'hAB || op == 'hB3 || op == 'hBB || op == 'hBA)) return "R9";
        if (m == 2) return "R10";
        if (m == 3) return "R11";
        if (m == 1 && (op == 'h18 || op == 'hB8)) return "R12";
        return "R13";
    endfunction

    // Place one instruction into a lane
    task automatic put_lane(input int k, input int m, input int op, input int rg,
                            input int md, input bit vl, input bit p66, input bit rw);
        win_map[2*k +: 2] = 2'(m);
        win_opc[8*k +: 8] = 8'(op);
        win_reg[3*k +: 3] = 3'(rg);
        win_mod[2*k +: 2] = 2'(md);
        win_vexl[k]       = vl;
        win_pfx66[k]      = p66;
        win_rexw[k]       = rw;
    endtask

    // Lane kinds for allocation tests: complex = 0F 94h, simple = one-byte 01h
    task automatic put_kind(input int k, input bit multi);
        if (multi) put_lane(k, 1, 'h94, 0, 3, 1'b0, 1'b0, 1'b0);
        else       put_lane(k, 0, 'h01, 0, 3, 1'b0, 1'b0, 1'b0);
    endtask

    initial begin
        #1000000;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int ev;
        int ec;
        int en;
        bit run;
        // R1: reset state, even with a valid window present
        put_kind(0, 1'b1);
        win_valid = 4'b0001;
        repeat (3) @(negedge clk);
        chk("R1", "slot_valid in reset", int'(slot_valid), 0);
        chk("R1", "consumed in reset", int'(consumed), 0);
        win_valid = 4'b0000;
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "slot_valid after reset", int'(slot_valid), 0);
        chk("R1", "slot_cplx after reset", int'(slot_cplx), 0);
        chk("R1", "consumed after reset", int'(consumed), 0);

        // R6..R13: class of every encoding, lane 0 alone
        for (int m = 0; m < 4; m++) begin
            for (int op = 0; op < 256; op++) begin
                for (int rg = 0; rg < 8; rg++) begin
                    for (int md = 0; md < 4; md += 3) begin
                        for (int vl = 0; vl < 2; vl++) begin
                            put_lane(0, m, op, rg, md, vl[0], rg[0] ^ op[0], rg[1] ^ md[0]);
                            win_valid = 4'b0001;
                            @(negedge clk);
                            chk(ref_tag(m, op), "slot_cplx[0]", int'(slot_cplx[0]),
                                int'(ref_multi(m, op, rg, md, vl[0])));
                            if (op == 0 && rg == 0)
                                chk("R2", "head slot valid", int'(slot_valid), 1);
                        end
                    end
                end
            end
        end

        // R2 R3 R4 R14: every valid mask against every class pattern
        for (int vm = 0; vm < 16; vm++) begin
            for (int cm = 0; cm < 16; cm++) begin
                for (int k = 0; k < 4; k++) put_kind(k, cm[k]);
                win_valid = 4'(vm);
                ev = 0; en = 0; run = 1'b1;
                for (int k = 0; k < 4; k++) begin
                    if (run && vm[k] && (k == 0 || !cm[k])) begin
                        ev |= (1 << k);
                        en++;
                    end else begin
                        run = 1'b0;
                    end
                end
                ec = (vm[0] && cm[0]) ? 1 : 0;
                @(negedge clk);
                chk(vm[0] ? "R3" : "R4", "slot_valid", int'(slot_valid), ev);
                chk("R2", "slot_cplx", int'(slot_cplx), ec);
                chk("R14", "consumed", int'(consumed), en);
            end
        end

        // R5: stall freezes a four-wide simple group and consumes nothing
        for (int k = 0; k < 4; k++) put_kind(k, 1'b0);
        win_valid = 4'b1111;
        @(negedge clk);
        chk("R3", "four simple", int'(slot_valid), 15);
        chk("R14", "four consumed", int'(consumed), 4);
        put_kind(0, 1'b1);
        win_valid = 4'b0001;
        stall = 1'b1;
        @(negedge clk);
        chk("R5", "slot_valid held", int'(slot_valid), 15);
        chk("R5", "slot_cplx held", int'(slot_cplx), 0);
        chk("R5", "consumed zero", int'(consumed), 0);
        @(negedge clk);
        chk("R5", "slot_valid still held", int'(slot_valid), 15);
        stall = 1'b0;
        #1;
        chk("R14", "no change before edge", int'(slot_valid), 15);
        @(negedge clk);
        chk("R5", "after release valid", int'(slot_valid), 1);
        chk("R5", "after release cplx", int'(slot_cplx), 1);
        chk("R5", "after release consumed", int'(consumed), 1);

        // R4: empty window after a full one
        win_valid = 4'b0000;
        @(negedge clk);
        chk("R4", "empty window", int'(slot_valid), 0);
        chk("R4", "empty consumed", int'(consumed), 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule